// File: doc/BRIEF.md
# PIN-Guarded Secret Store

This block keeps one secret key behind a short decimal PIN. A host that need not be trusted sends commands over a simple one-word command port. A store command sets a new PIN and secret and starts a fresh attempt budget. A guess command returns the secret when the PIN matches and spends one attempt when it does not. Once ten attempts have been spent, the secret is erased, and no guess can succeed until a new store.

The stored PIN, secret and failure counter model persistent storage. A warm reset leaves them alone, but a power-on reset clears them. Every change to them goes through one commit strobe, so each change lands whole in a single clock edge. A guess pays for its attempt at the first edge after it is accepted, before any comparison has started. Pulsing reset in the middle of a guess therefore cannot give the attempt back. The PIN comparison walks all digits on every command, and every command answers after the same number of cycles. The response timing therefore tells a host nothing about how close a guess was.

Top module: `pin_vault`

## Requirements
- R1: The PIN is four BCD digits, one per nibble of `cmdPin`. A store whose PIN has any nibble above 9 answers `respOk`=0 and leaves the stored PIN, secret and counter as they were.
- R2: A command is accepted when `cmdValid` is high at a rising edge while the block is idle. `respValid` is high for exactly one cycle, which starts at the sixth rising edge after the accept edge. This holds for both command types and for every PIN value and outcome.
- R3: A command presented while an earlier one is still in progress is ignored and changes nothing.
- R4: A guess equal to the stored PIN, made while the counter is below 10, answers `respOk`=1 with the stored secret on `respSecret` and resets the counter to 0.
- R5: A guess that differs from the stored PIN answers `respOk`=0 and adds one to the counter. This includes a guess with non-BCD nibbles.
- R6: When the counter reaches 10 through a failed guess, the secret is erased. While the counter is at 10, every guess answers `respOk`=0 with a zero secret, even the old correct PIN. Only a store lifts this lock.
- R7: A guess adds to the counter at the first rising edge after its accept edge, unless warm reset is low at that edge. A warm reset at any edge never lowers the counter and cancels the pending response.
- R8: A warm reset (`rstN` low) keeps the stored PIN, secret and counter. A power-on reset (`porN` low) erases them and sets the counter to 10, so the store is locked until the first store.
- R9: A store with a valid PIN replaces the PIN and secret, sets the counter to 0, and answers `respOk`=1 with a zero `respSecret`.
- R10: `respSecret` is all zero in every cycle except the response cycle of a successful guess.
- R11: All four digits are compared on every guess. A mismatch in any single digit position makes the guess fail, with the same latency as any other guess.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Warm reset, active low, synchronous; leaves the persistent store intact |
| porN | input | 1 | Power-on reset, active low, synchronous; erases the persistent store |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 1 | 0 = store, 1 = guess |
| cmdPin | input | 16 | Four BCD digits, digit 0 in bits 3:0 |
| cmdSecret | input | 128 | Secret to keep (store only) |
| respValid | output | 1 | One-cycle response strobe |
| respOk | output | 1 | Command succeeded |
| respSecret | output | 128 | Secret on a successful guess, zero otherwise |

## Verification
A failure counter that is off by one stays hidden at the ports until the attempt budget runs out. It shows only as a guess near the limit that succeeds when it should fail, or fails when it should succeed, so the bench drives the counter to the limit on both sides after each interrupted guess. A fault in the digit accumulator or in the choice of commit kind shows in the response cycle, six edges after acceptance, as a wrong `respOk` or `respSecret`. A commit that should not have happened shows on the next command that reads the stored state.

// File: rtl/pin_vault_pkg.sv
`timescale 1ns/1ps
package pin_vault_pkg;

  localparam logic OP_STORE = 1'b0;
  localparam logic OP_GUESS = 1'b1;

  // kind of write applied to the persistent store in one edge
  typedef enum logic [2:0] {
    CM_NONE,
    CM_CHARGE,
    CM_STORE,
    CM_CLEAR,
    CM_WIPE
  } commitKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        latchReq;
    logic        cmpStep;
    logic        respLoad;
    logic        respOk;
    logic        respReveal;
    commitKind_e commit;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic reqIsGuess;
    logic reqLocked;
    logic reqPinValid;
    logic pinMatch;
    logic cntAtLimit;
  } dpStatus_t;

endpackage

// File: rtl/pin_vault_ctrl.sv
`timescale 1ns/1ps
module pin_vault_ctrl
  import pin_vault_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  porN,
  input  logic                  cmdValid,
  input  dpStatus_t             status,
  output ctrlStrobe_t           strobe,
  output logic [IDX_W-1:0]      digitSel
);

  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [IDX_W-1:0] LAST_DIGIT = IDX_W'(DIGITS - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHARGE,
    ST_CMP,
    ST_SETTLE
  } vaultState_e;

  vaultState_e stateQ, stateD;
  logic [IDX_W-1:0] digitQ, digitD;

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      stateQ <= ST_IDLE;
      digitQ <= '0;
    end else begin
      stateQ <= stateD;
      digitQ <= digitD;
    end
  end

  always_comb begin
    stateD            = stateQ;
    digitD            = digitQ;
    strobe            = '0;
    strobe.commit     = CM_NONE;
    unique case (stateQ)
      ST_IDLE: begin
        if (cmdValid) begin
          strobe.latchReq = 1'b1;
          stateD          = ST_CHARGE;
        end
      end
      ST_CHARGE: begin
        // pay for the attempt before any digit is looked at
        if (status.reqIsGuess && !status.reqLocked) strobe.commit = CM_CHARGE;
        digitD = '0;
        stateD = ST_CMP;
      end
      ST_CMP: begin
        strobe.cmpStep = 1'b1;
        if (digitQ == LAST_DIGIT) begin
          stateD = ST_SETTLE;
        end else begin
          digitD = digitQ + 1'b1;
        end
      end
      ST_SETTLE: begin
        strobe.respLoad = 1'b1;
        stateD          = ST_IDLE;
        if (!status.reqIsGuess) begin
          if (status.reqPinValid) begin
            strobe.commit = CM_STORE;
            strobe.respOk = 1'b1;
          end
        end else if (!status.reqLocked && status.pinMatch) begin
          strobe.commit     = CM_CLEAR;
          strobe.respOk     = 1'b1;
          strobe.respReveal = 1'b1;
        end else if (status.cntAtLimit) begin
          strobe.commit = CM_WIPE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign digitSel = digitQ;

endmodule

// File: rtl/pin_vault_dp.sv
`timescale 1ns/1ps
module pin_vault_dp
  import pin_vault_pkg::*;
#(
  parameter int DIGITS   = 4,
  parameter int SECRET_W = 128,
  parameter int LIMIT    = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  porN,
  input  ctrlStrobe_t           strobe,
  input  logic [IDX_W-1:0]      digitSel,
  input  logic                  cmdOp,
  input  logic [PIN_W-1:0]      cmdPin,
  input  logic [SECRET_W-1:0]   cmdSecret,
  output dpStatus_t             status,
  output logic                  respValid,
  output logic                  respOk,
  output logic [SECRET_W-1:0]   respSecret,
  output logic [CNT_W-1:0]      failCnt
);

  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int PIN_W = 4 * DIGITS;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(LIMIT);

  // persistent store: survives rstN, cleared by porN
  logic [PIN_W-1:0]    storedPin;
  logic [SECRET_W-1:0] storedSecret;
  logic [CNT_W-1:0]    cntQ;

  // request registers: volatile
  logic                reqOp;
  logic [PIN_W-1:0]    reqPin;
  logic [SECRET_W-1:0] reqSecret;
  logic                reqLocked;
  logic                missAcc;

  logic [DIGITS-1:0]   digitMiss;
  logic [DIGITS-1:0]   digitOk;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign digitMiss[d] = (reqPin[4*d +: 4] != storedPin[4*d +: 4]);
    assign digitOk[d]   = (reqPin[4*d +: 4] <= 4'd9);
  end

  // single commit path into persistent state
  always_ff @(posedge clk) begin
    if (!porN) begin
      storedPin    <= '0;
      storedSecret <= '0;
      cntQ         <= CNT_LIMIT;
    end else if (rstN) begin
      unique case (strobe.commit)
        CM_CHARGE: cntQ <= cntQ + 1'b1;
        CM_STORE: begin
          storedPin    <= reqPin;
          storedSecret <= reqSecret;
          cntQ         <= '0;
        end
        CM_CLEAR: cntQ <= '0;
        CM_WIPE: begin
          storedPin    <= '0;
          storedSecret <= '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      reqOp      <= OP_STORE;
      reqPin     <= '0;
      reqSecret  <= '0;
      reqLocked  <= 1'b0;
      missAcc    <= 1'b0;
      respValid  <= 1'b0;
      respOk     <= 1'b0;
      respSecret <= '0;
    end else begin
      if (strobe.latchReq) begin
        reqOp     <= cmdOp;
        reqPin    <= cmdPin;
        reqSecret <= cmdSecret;
        reqLocked <= (cntQ == CNT_LIMIT);
        missAcc   <= 1'b0;
      end else if (strobe.cmpStep) begin
        missAcc <= missAcc | digitMiss[digitSel];
      end
      respValid  <= strobe.respLoad;
      respOk     <= strobe.respLoad & strobe.respOk;
      respSecret <= (strobe.respLoad && strobe.respReveal) ? storedSecret : '0;
    end
  end

  always_comb begin
    status             = '0;
    status.reqIsGuess  = (reqOp == OP_GUESS);
    status.reqLocked   = reqLocked;
    status.reqPinValid = &digitOk;
    status.pinMatch    = !missAcc;
    status.cntAtLimit  = (cntQ == CNT_LIMIT);
  end

  assign failCnt = cntQ;

endmodule

// File: rtl/pin_vault.sv
`timescale 1ns/1ps
module pin_vault
  import pin_vault_pkg::*;
#(
  parameter int DIGITS    = 4,
  parameter int SECRET_W  = 128,
  parameter int MAX_FAILS = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  porN,
  input  logic                  cmdValid,
  input  logic                  cmdOp,
  input  logic [4*DIGITS-1:0]   cmdPin,
  input  logic [SECRET_W-1:0]   cmdSecret,
  output logic                  respValid,
  output logic                  respOk,
  output logic [SECRET_W-1:0]   respSecret
);

  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int CNT_W = $clog2(MAX_FAILS + 1);

  ctrlStrobe_t       strobe;
  dpStatus_t         status;
  logic [IDX_W-1:0]  digitSel;
  logic [CNT_W-1:0]  failCnt;
  logic              acceptPulse;

  pin_vault_ctrl #(
    .DIGITS(DIGITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .porN     (porN),
    .cmdValid (cmdValid),
    .status   (status),
    .strobe   (strobe),
    .digitSel (digitSel)
  );

  pin_vault_dp #(
    .DIGITS   (DIGITS),
    .SECRET_W (SECRET_W),
    .LIMIT    (MAX_FAILS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .porN       (porN),
    .strobe     (strobe),
    .digitSel   (digitSel),
    .cmdOp      (cmdOp),
    .cmdPin     (cmdPin),
    .cmdSecret  (cmdSecret),
    .status     (status),
    .respValid  (respValid),
    .respOk     (respOk),
    .respSecret (respSecret),
    .failCnt    (failCnt)
  );

  assign acceptPulse = strobe.latchReq;

endmodule

// File: rtl/pin_vault_chk.sv
`timescale 1ns/1ps
module pin_vault_chk #(
  parameter int DIGITS   = 4,
  parameter int SECRET_W = 128,
  parameter int LIMIT    = 10
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       porN,
  input logic                       acceptPulse,
  input logic                       respValid,
  input logic                       respOk,
  input logic [SECRET_W-1:0]        respSecret,
  input logic [$clog2(LIMIT+1)-1:0] failCnt
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam int LAT   = DIGITS + 2;
  localparam int AGE_W = $clog2(LAT + 2) + 1;

  logic             pending;
  logic [AGE_W-1:0] age;

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      pending <= 1'b0;
      age     <= '0;
    end else if (acceptPulse) begin
      pending <= 1'b1;
      age     <= '0;
    end else if (pending) begin
      if (respValid) pending <= 1'b0;
      age <= age + 1'b1;
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!porN || !rstN)
    respValid |-> (pending && age == AGE_W'(LAT)));

  a_r2_pulse: assert property (@(posedge clk) disable iff (!porN || !rstN)
    respValid |=> !respValid);

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!porN || !rstN)
    acceptPulse |-> (!pending || respValid));

  a_r10_secret_gated: assert property (@(posedge clk) disable iff (!porN || !rstN)
    !(respValid && respOk) |-> (respSecret == '0));

  a_r6_cap: assert property (@(posedge clk) disable iff (!porN)
    failCnt <= CNT_W'(LIMIT));

  a_r7_no_drop: assert property (@(posedge clk) disable iff (!porN)
    (failCnt < $past(failCnt)) |-> (respValid && respOk));

  a_r7_unit_step: assert property (@(posedge clk) disable iff (!porN)
    (failCnt > $past(failCnt)) |-> ({1'b0, failCnt} == {1'b0, $past(failCnt)} + 1'b1));

endmodule

bind pin_vault pin_vault_chk #(
  .DIGITS   (DIGITS),
  .SECRET_W (SECRET_W),
  .LIMIT    (MAX_FAILS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .porN        (porN),
  .acceptPulse (acceptPulse),
  .respValid   (respValid),
  .respOk      (respOk),
  .respSecret  (respSecret),
  .failCnt     (failCnt)
);

// File: tb/tb_pin_vault.sv
`timescale 1ns/1ps
module tb_pin_vault;

  localparam int LIMIT = 10;
  localparam int LAT   = 6;

  logic         clk;
  logic         rstN;
  logic         porN;
  logic         cmdValid;
  logic         cmdOp;
  logic [15:0]  cmdPin;
  logic [127:0] cmdSecret;
  logic         respValid;
  logic         respOk;
  logic [127:0] respSecret;

  int nChecks = 0;
  int nFail   = 0;

  // reference model state, from the requirements
  logic [15:0]  mPin;
  logic [127:0] mSecret;
  int           mCnt;

  pin_vault #(
    .DIGITS    (4),
    .SECRET_W  (128),
    .MAX_FAILS (LIMIT)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .porN       (porN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdPin     (cmdPin),
    .cmdSecret  (cmdSecret),
    .respValid  (respValid),
    .respOk     (respOk),
    .respSecret (respSecret)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit isBcd(input logic [15:0] p);
    for (int d = 0; d < 4; d++) if (p[4*d +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [15:0] wrongOf(input logic [15:0] p);
    return p ^ 16'h0001;
  endfunction

  task automatic issue(input logic op, input logic [15:0] pin, input logic [127:0] sec,
                       input bit noisy, input string req);
    logic expOk;
    logic [127:0] expSec;
    int lat;
    bit seen;
    logic gotOk;
    logic [127:0] gotSec;
    expOk = 1'b0;
    expSec = '0;
    gotOk = 1'bx;
    gotSec = 'x;
    if (op == 1'b0) begin
      if (isBcd(pin)) begin
        mPin = pin; mSecret = sec; mCnt = 0; expOk = 1'b1;
      end
    end else if (mCnt >= LIMIT) begin
      mSecret = '0; mPin = '0;
    end else begin
      mCnt++;
      if (pin == mPin) begin
        expOk = 1'b1; expSec = mSecret; mCnt = 0;
      end else if (mCnt == LIMIT) begin
        mSecret = '0; mPin = '0;
      end
    end
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdPin = pin; cmdSecret = sec;
    @(posedge clk);
    @(negedge clk);
    if (noisy) begin
      cmdValid = 1'b1; cmdOp = 1'b0; cmdPin = 16'h1111; cmdSecret = '1;
    end else begin
      cmdValid = 1'b0;
    end
    lat = 0;
    seen = 1'b0;
    while (!seen && lat < 16) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (respValid) begin
        seen = 1'b1; gotOk = respOk; gotSec = respSecret;
      end
      if (!(noisy && lat < 5)) cmdValid = 1'b0;
    end
    chk("R2", "latency", 128'(lat), 128'(LAT));
    chk(req, "respOk", 128'(gotOk), 128'(expOk));
    chk(expOk ? req : "R10", "respSecret", gotSec, expSec);
    @(negedge clk);
    chk("R2", "pulse width", 128'(respValid), 128'd0);
  endtask

  task automatic doStore(input logic [15:0] pin, input logic [127:0] sec, input string req);
    issue(1'b0, pin, sec, 1'b0, req);
  endtask

  task automatic doGuess(input logic [15:0] pin, input string req);
    issue(1'b1, pin, '0, 1'b0, req);
  endtask

  // guess cut short by a warm reset sampled t edges after its accept edge
  task automatic intr(input logic [15:0] pin, input int t);
    bit sawResp;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 1'b1; cmdPin = pin;
    if (t == 0) rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    if (t == 0) begin
      rstN = 1'b1;
    end else begin
      repeat (t - 1) @(negedge clk);
      rstN = 1'b0;
      @(negedge clk);
      rstN = 1'b1;
    end
    if (t >= 2 && mCnt < LIMIT) mCnt++;
    sawResp = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (respValid) sawResp = 1'b1;
    end
    chk("R7", "response after interrupted guess", 128'(sawResp), 128'd0);
  endtask

  task automatic powerOn();
    @(negedge clk);
    porN = 1'b0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    mPin = '0; mSecret = '0; mCnt = LIMIT;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0]  pinA;
    logic [127:0] secA;
    logic [127:0] secB;
    rstN = 1'b0; porN = 1'b0;
    cmdValid = 1'b0; cmdOp = 1'b0; cmdPin = '0; cmdSecret = '0;
    mPin = '0; mSecret = '0; mCnt = LIMIT;
    repeat (4) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);

    // R8: state after power-on
    chk("R8", "respValid after power-on", 128'(respValid), 128'd0);
    chk("R8", "respOk after power-on", 128'(respOk), 128'd0);
    chk("R10", "respSecret after power-on", respSecret, 128'd0);
    doGuess(16'h0000, "R8");

    // R9 / R4: basic store and guess
    pinA = 16'h1234;
    secA = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    doStore(pinA, secA, "R9");
    doGuess(pinA, "R4");

    // R11: each digit position wrong by each other value
    for (int d = 0; d < 4; d++) begin
      for (int v = 0; v < 10; v++) begin
        logic [15:0] g;
        g = pinA;
        if (pinA[4*d +: 4] != 4'(v)) begin
          g[4*d +: 4] = 4'(v);
          if (mCnt >= LIMIT - 1) doGuess(pinA, "R4");
          doGuess(g, "R11");
        end
      end
    end
    doGuess(pinA, "R4");

    // R5: a non-BCD guess is spent as a wrong guess
    doGuess(16'hFFFF, "R5");
    doGuess(16'h12A4, "R5");
    doGuess(pinA, "R4");

    // R6: ten failures erase the secret and lock
    for (int i = 0; i < LIMIT; i++) doGuess(wrongOf(pinA), "R5");
    doGuess(pinA, "R6");
    doGuess(pinA, "R6");
    secB = 128'hdead_beef_0000_1111_2222_3333_4444_5555;
    doStore(16'h9070, secB, "R9");
    doGuess(16'h9070, "R6");

    // R1: a store with a non-BCD nibble in any position is refused
    for (int d = 0; d < 4; d++) begin
      logic [15:0] bad;
      bad = 16'h5555;
      bad[4*d +: 4] = 4'hA + 4'(d);
      doStore(bad, '1, "R1");
    end
    doGuess(16'h9070, "R1");

    // R3: commands presented while busy are ignored
    issue(1'b1, 16'h9070, '0, 1'b1, "R3");
    issue(1'b1, 16'h0000, '0, 1'b1, "R3");
    issue(1'b0, 16'h4321, secA, 1'b1, "R3");
    doGuess(16'h1111, "R3");
    doGuess(16'h4321, "R3");

    // R8: warm reset keeps the store, power-on erases it
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    doGuess(16'h4321, "R8");
    doGuess(16'h4320, "R5");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    doGuess(16'h4321, "R8");
    powerOn();
    doGuess(16'h4321, "R8");
    doGuess(16'h0000, "R8");

    // R7: warm reset at every edge of a guess, probing the counter on both sides of the limit
    for (int t = 0; t <= LAT; t++) begin
      for (int variant = 0; variant < 2; variant++) begin
        int n;
        doStore(16'h2580, secA ^ 128'(t), "R9");
        for (int k = 0; k < t % 3; k++) doGuess(16'h2581, "R5");
        intr(16'h2580, t);
        n = (variant == 0) ? (LIMIT - 1 - mCnt) : (LIMIT - mCnt);
        for (int k = 0; k < n; k++) doGuess(16'h2581, "R7");
        doGuess(16'h2580, "R7");
      end
    end

    // randomized guesses
    doStore(16'h0417, secB, "R9");
    for (int i = 0; i < 250; i++) begin
      logic [15:0] g;
      for (int d = 0; d < 4; d++) g[4*d +: 4] = 4'($urandom % 10);
      if (mCnt >= LIMIT - 2 || (i % 41) == 0) begin
        doStore(g, {$urandom, $urandom, $urandom, $urandom}, "R9");
      end else begin
        if (($urandom % 5) == 0) g = mPin;
        doGuess(g, (g == mPin) ? "R4" : "R5");
      end
    end

    summary();
    $finish;
  end

endmodule